// File: doc/BRIEF.md
# Interleaved flash instruction prefetch accelerator

This block sits between a 32-bit processor fetch port and a slow flash array that is split into two banks. Each bank can run its own read at the same time as the other. Consecutive 128-bit lines alternate between the banks: the line number is the byte address shifted right by four, and its lowest bit picks the bank. Each bank keeps two single-line buffers. The trail buffer is filled by demand reads, so it still holds loop bodies after a backward branch. The prefetch buffer is filled by speculative reads of the next line that the same bank owns. A third single-line buffer serves data reads, which never trigger speculation.

The processor holds `req_i`, `data_i`, `half_i` and `addr_i` steady until `ready_o` is sampled high. On a buffer hit, `ready_o` rises in the same cycle and the requested word or halfword is picked out of the line. On a miss, the wait logic holds `ready_o` low while the bank reads the line. Each read lasts a programmable number of cycles, set on `rd_cycles_i`. The flash arrays are behavioural stubs whose contents are a fixed function of the address.

Top module: `flash_accel`

## Requirements
- R1: Line number N = address bits 31:4 lives in bank N[0]. An instruction miss on line N also starts a read of line N+1 in the other bank, in parallel, unless that line is already buffered or being read there. A fetch of line N+1 made right after the miss completes with no wait.
- R2: The flash word at byte address A is {A[17:2] xor 16'h5A3C, A[17:2]}. With `half_i`=0, `rdata_o` is the word at A[3:2] of the line. With `half_i`=1, `rdata_o` is the halfword at A[3:1] (A[1]=1 selects bits 31:16 of the word), zero-extended.
- R3: An instruction fetch that misses both buffers of its bank, with no read of that line in flight there, keeps `ready_o` low for exactly T+1 cycles before completing, where T is the read length. The line is then placed in that bank's trail buffer.
- R4: An instruction fetch that hits a trail buffer completes in its first cycle. This holds for re-running a loop whose lines were read before.
- R5: Delivering the last instruction of line N starts a read of line N+2 in the same bank, into its prefetch buffer, if that bank is idle. The last instruction is word offset 3 for a word fetch, or halfword offset 7 for a halfword fetch. Once that read ends, a fetch of line N+2 completes with no wait. Delivering any other offset starts nothing.
- R6: A fetch of a line that its bank is already reading is not reissued. It completes one cycle after that read ends.
- R7: An instruction miss to a different line, in a bank with a prefetch in flight, restarts that bank on the new line. The abandoned line is not stored.
- R8: The read length is T = `rd_cycles_i` cycles, and a value of 0 counts as 1.
- R9: A data read (`data_i`=1) is served only from the data line buffer. A miss stalls T+1 cycles and fills only that buffer, and a hit completes at once. No prefetch ever follows a data read, and the instruction buffers are left unchanged.
- R10: Reset empties every buffer and cancels every read, so the first fetch after reset is a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rd_cycles_i | input | RDC_W | Flash read length in cycles (0 treated as 1) |
| req_i | input | 1 | Read request, held until completed |
| data_i | input | 1 | 1 = data read, 0 = instruction fetch |
| half_i | input | 1 | 1 = halfword access, 0 = word access |
| addr_i | input | 31 | Byte address bits 31:1 |
| ready_o | output | 1 | Request completes in this cycle |
| rdata_o | output | 32 | Selected word or zero-extended halfword |

## Verification
The bench builds the block with the default RDC_W of 4 and changes `rd_cycles_i` between scenarios. It uses 0, 1 and 7 to check the clamp and the T+1 stall at both ends. It uses 3 so that word-per-cycle streaming outruns no prefetch, which makes the zero-stall sequential claim exact. It uses 5 and 6 so that a fetch issued the cycle after a last-instruction delivery finds the speculative read still in flight. That brings the await and cancel paths within reach.

// File: rtl/flash_accel_pkg.sv
package flash_accel_pkg;

    localparam int ADDR_W = 32;
    localparam int LINE_W = 128;
    localparam int WORD_W = 32;
    localparam int HALF_W = WORD_W / 2;
    localparam int OFS_W  = $clog2(LINE_W / 8);
    localparam int TAG_W  = ADDR_W - OFS_W;
    localparam int WSEL_W = OFS_W - 2;
    localparam int NBANK  = 2;
    localparam int IDX_W  = 16;

    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [LINE_W-1:0] line_t;

    typedef enum logic [1:0] {
        RD_NONE,
        RD_TRAIL,
        RD_PREF,
        RD_DATA
    } rd_kind_e;

    typedef struct packed {
        logic  vld;
        tag_t  tag;
        line_t line;
    } lbuf_t;

    typedef struct packed {
        lbuf_t    [NBANK-1:0] trail;
        lbuf_t    [NBANK-1:0] pref;
        lbuf_t                dbuf;
        rd_kind_e [NBANK-1:0] kind;
    } ctl_t;

    function automatic logic [WORD_W-1:0] flash_word(input logic [IDX_W-1:0] idx);
        return {idx ^ 16'h5A3C, idx};
    endfunction

endpackage

// File: rtl/fa_flash_bank.sv
module fa_flash_bank
    import flash_accel_pkg::*;
#(
    parameter int RDC_W = 4,
    parameter int BANK  = 0
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  tag_t             tag_i,
    input  logic [RDC_W-1:0] rd_cycles_i,
    output logic             busy_o,
    output logic             done_o,
    output tag_t             tag_o,
    output line_t            line_o
);

    typedef struct packed {
        logic             busy;
        logic [RDC_W-1:0] cnt;
        tag_t             tag;
    } bank_st_t;

    bank_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (start_i) begin
            st_d.busy = 1'b1;
            st_d.cnt  = (rd_cycles_i == '0) ? '0 : rd_cycles_i - 1'b1;
            st_d.tag  = tag_i;
        end else if (st_q.busy) begin
            if (st_q.cnt == '0) st_d.busy = 1'b0;
            else                st_d.cnt  = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign busy_o = st_q.busy;
    assign done_o = st_q.busy && (st_q.cnt == '0);
    assign tag_o  = st_q.tag;

    for (genvar k = 0; k < LINE_W / WORD_W; k++) begin : g_word
        assign line_o[k*WORD_W +: WORD_W] =
            flash_word({st_q.tag[IDX_W-WSEL_W-1:0], WSEL_W'(k)});
    end

    assert_start_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_i |=> busy_o);
    assert_short_read_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && rd_cycles_i <= 1) |=> done_o);
    assert_bank_parity_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_i |-> (tag_i[0] == 1'(BANK)));

endmodule

// File: rtl/fa_line_sel.sv
module fa_line_sel
    import flash_accel_pkg::*;
(
    input  line_t              line_i,
    input  logic [OFS_W-1:1]   ofs_i,
    input  logic               half_i,
    output logic [WORD_W-1:0]  data_o
);

    logic [WORD_W-1:0] word;
    logic [HALF_W-1:0] hw;

    always_comb begin
        word   = line_i[ofs_i[OFS_W-1:2]*WORD_W +: WORD_W];
        hw     = ofs_i[1] ? word[WORD_W-1:HALF_W] : word[HALF_W-1:0];
        data_o = half_i ? {{HALF_W{1'b0}}, hw} : word;
    end

endmodule

// File: rtl/flash_accel.sv
module flash_accel
    import flash_accel_pkg::*;
#(
    parameter int RDC_W = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [RDC_W-1:0]  rd_cycles_i,
    input  logic              req_i,
    input  logic              data_i,
    input  logic              half_i,
    input  logic [ADDR_W-1:1] addr_i,
    output logic              ready_o,
    output logic [WORD_W-1:0] rdata_o
);

    ctl_t st_d, st_q;

    logic [NBANK-1:0] fbusy, fdone, start;
    tag_t             ftag  [NBANK];
    line_t            fline [NBANK];
    tag_t             stag  [NBANK];
    rd_kind_e         skind [NBANK];

    logic [NBANK-1:0] trail_hit, pref_hit, infl;
    tag_t  req_tag, nxt_tag, far_tag;
    logic  cur, oth, inst_rq, dat_rq, inst_hit, d_hit, infl_cur, start_cur;
    logic  last_ins, pref_start;
    line_t hit_line;

    assign req_tag = addr_i[ADDR_W-1:OFS_W];
    assign cur     = addr_i[OFS_W];
    assign oth     = ~cur;
    assign inst_rq = req_i && !data_i;
    assign dat_rq  = req_i && data_i;
    assign nxt_tag = req_tag + TAG_W'(1);
    assign far_tag = req_tag + TAG_W'(2);
    assign last_ins = half_i ? (addr_i[OFS_W-1:1] == '1) : (addr_i[OFS_W-1:2] == '1);

    always_comb begin
        st_d  = st_q;
        start = '0;
        for (int b = 0; b < NBANK; b++) begin
            skind[b]     = RD_NONE;
            stag[b]      = '0;
            trail_hit[b] = st_q.trail[b].vld && (st_q.trail[b].tag == req_tag);
            pref_hit[b]  = st_q.pref[b].vld && (st_q.pref[b].tag == req_tag);
            infl[b]      = fbusy[b] && (ftag[b] == req_tag);
            if (fdone[b]) begin
                case (st_q.kind[b])
                    RD_TRAIL: st_d.trail[b] = {1'b1, ftag[b], fline[b]};
                    RD_PREF:  st_d.pref[b]  = {1'b1, ftag[b], fline[b]};
                    RD_DATA:  st_d.dbuf     = {1'b1, ftag[b], fline[b]};
                    default:  ;
                endcase
            end
        end

        inst_hit = trail_hit[cur] || pref_hit[cur];
        d_hit    = st_q.dbuf.vld && (st_q.dbuf.tag == req_tag);
        infl_cur = infl[cur];
        ready_o  = inst_rq ? inst_hit : (dat_rq && d_hit);
        if (data_i)              hit_line = st_q.dbuf.line;
        else if (trail_hit[cur]) hit_line = st_q.trail[cur].line;
        else                     hit_line = st_q.pref[cur].line;

        // demand miss: requested line plus its neighbour in the other bank
        if (inst_rq && !inst_hit && !infl_cur &&
            !(fbusy[cur] && st_q.kind[cur] == RD_DATA)) begin
            start[cur] = 1'b1;
            stag[cur]  = req_tag;
            skind[cur] = RD_TRAIL;
            if (!(st_q.trail[oth].vld && st_q.trail[oth].tag == nxt_tag) &&
                !(st_q.pref[oth].vld && st_q.pref[oth].tag == nxt_tag) &&
                !(fbusy[oth] && (ftag[oth] == nxt_tag || st_q.kind[oth] == RD_DATA))) begin
                start[oth] = 1'b1;
                stag[oth]  = nxt_tag;
                skind[oth] = RD_TRAIL;
            end
        end

        // speculative read of this bank's next own line
        if (inst_rq && inst_hit && last_ins && !fbusy[cur] &&
            !(st_q.trail[cur].vld && st_q.trail[cur].tag == far_tag) &&
            !(st_q.pref[cur].vld && st_q.pref[cur].tag == far_tag)) begin
            start[cur] = 1'b1;
            stag[cur]  = far_tag;
            skind[cur] = RD_PREF;
        end

        // data miss waits for an idle bank, never speculates
        if (dat_rq && !d_hit && !fbusy[cur]) begin
            start[cur] = 1'b1;
            stag[cur]  = req_tag;
            skind[cur] = RD_DATA;
        end

        for (int b = 0; b < NBANK; b++) begin
            if (start[b]) st_d.kind[b] = skind[b];
        end

        start_cur  = start[cur];
        pref_start = (start[0] && skind[0] == RD_PREF) || (start[1] && skind[1] == RD_PREF);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    for (genvar gb = 0; gb < NBANK; gb++) begin : g_bank
        fa_flash_bank #(.RDC_W(RDC_W), .BANK(gb)) u_bank (
            .clk_i       (clk_i),
            .rst_ni      (rst_ni),
            .start_i     (start[gb]),
            .tag_i       (stag[gb]),
            .rd_cycles_i (rd_cycles_i),
            .busy_o      (fbusy[gb]),
            .done_o      (fdone[gb]),
            .tag_o       (ftag[gb]),
            .line_o      (fline[gb])
        );

        assert_trail_fill_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (fdone[gb] && st_q.kind[gb] == RD_TRAIL) |=>
            (st_q.trail[gb].vld && st_q.trail[gb].tag == $past(ftag[gb])));
    end

    fa_line_sel u_sel (
        .line_i (hit_line),
        .ofs_i  (addr_i[OFS_W-1:1]),
        .half_i (half_i),
        .data_o (rdata_o)
    );

    assert_await_inflight_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (inst_rq && infl_cur) |-> !start_cur);
    assert_no_data_prefetch_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pref_start |-> (req_i && !data_i && ready_o));

endmodule

// File: tb/flash_accel_bench.sv
module flash_accel_bench;

    localparam int RDC_W = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [RDC_W-1:0] rdc;
    logic             req, isd, half;
    logic [31:0]      addr;
    logic             ready;
    logic [31:0]      rdata;
    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    flash_accel #(.RDC_W(RDC_W)) u_flash_accel (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .rd_cycles_i (rdc),
        .req_i       (req),
        .data_i      (isd),
        .half_i      (half),
        .addr_i      (addr[31:1]),
        .ready_o     (ready),
        .rdata_o     (rdata)
    );

    function automatic logic [31:0] exp_val(input logic [31:0] a, input bit h);
        logic [15:0] idx;
        logic [31:0] w;
        idx = a[17:2];
        w   = {idx ^ 16'h5A3C, idx};
        if (!h) return w;
        return {16'h0, a[1] ? w[31:16] : w[15:0]};
    endfunction

    task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic access(input logic [31:0] a, input bit d, input bit h,
                          output int waits, output logic [31:0] v);
        @(negedge clk);
        req = 1'b1; isd = d; half = h; addr = a; waits = 0;
        #1;
        while (!ready && waits < 200) begin
            waits++;
            @(negedge clk);
            #1;
        end
        v = rdata;
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        req = 1'b0;
        repeat (n - 1) @(negedge clk);
    endtask

    task automatic fetch_chk(input logic [31:0] a, input bit d, input bit h,
                             input int exp_waits, input string what);
        int w;
        logic [31:0] v;
        access(a, d, h, w, v);
        chk(w == exp_waits, {what, " waits"}, 32'(w), 32'(exp_waits));
        chk(v == exp_val(a, h), {what, " data"}, v, exp_val(a, h));
    endtask

    task automatic t_reset_r10();
        rdc = 3;
        #1;
        chk(ready == 1'b0, "R10 idle after reset", 32'(ready), 0);
        fetch_chk(32'h1000, 0, 0, 4, "R10 first fetch misses");
        fetch_chk(32'h1004, 0, 0, 0, "R4 same line hits");
        idle(2);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        fetch_chk(32'h1000, 0, 0, 4, "R10 buffers cleared");
        idle(10);
    endtask

    task automatic t_miss_pair_r3();
        rdc = 5;
        idle(10);
        fetch_chk(32'h2008, 0, 0, 6, "R3 miss stall");
        fetch_chk(32'h2010, 0, 0, 0, "R1 neighbour read in parallel");
        fetch_chk(32'h2004, 0, 0, 0, "R4 trail hit");
        idle(10);
    endtask

    task automatic t_timing_r8();
        rdc = 0;
        idle(10);
        fetch_chk(32'h3000, 0, 0, 2, "R8 zero clamps to one");
        rdc = 7;
        idle(10);
        fetch_chk(32'h3400, 0, 0, 8, "R8 seven cycle read");
        rdc = 1;
        idle(10);
        fetch_chk(32'h3800, 0, 0, 2, "R8 one cycle read");
        idle(10);
    endtask

    task automatic t_select_r2();
        rdc = 2;
        idle(10);
        fetch_chk(32'h4006, 0, 1, 3, "R2 halfword miss");
        for (int i = 0; i < 8; i++) fetch_chk(32'h4000 + 32'(2 * i), 0, 1, 0, "R2 halfword select");
        fetch_chk(32'h4008, 0, 0, 0, "R2 word select");
        idle(10);
    endtask

    task automatic t_pref_r5();
        rdc = 3;
        idle(10);
        fetch_chk(32'h600C, 0, 0, 4, "R5 last word miss");
        idle(6);
        fetch_chk(32'h6024, 0, 0, 0, "R5 forward hit in prefetch");
        idle(10);
        fetch_chk(32'h700E, 0, 1, 4, "R5 last halfword miss");
        idle(6);
        fetch_chk(32'h7020, 0, 0, 0, "R5 halfword triggers prefetch");
        idle(10);
        fetch_chk(32'h710C, 0, 1, 4, "R5 non-last halfword miss");
        idle(6);
        fetch_chk(32'h7120, 0, 0, 4, "R5 no prefetch before last");
        idle(10);
    endtask

    task automatic t_stream_r5();
        int sum = 0;
        int w;
        logic [31:0] v;
        rdc = 3;
        idle(10);
        for (int l = 0; l < 6; l++) begin
            for (int k = 0; k < 4; k++) begin
                access(32'h5000 + 32'(16 * l + 4 * k), 0, 0, w, v);
                sum += w;
                chk(v == exp_val(32'h5000 + 32'(16 * l + 4 * k), 0), "R5 stream data",
                    v, exp_val(32'h5000 + 32'(16 * l + 4 * k), 0));
            end
        end
        idle(10);
        chk(sum == 4, "R5 sequential stream stalls only once", 32'(sum), 4);
    endtask

    task automatic t_loop_r4();
        int sum = 0;
        int w;
        logic [31:0] v;
        rdc = 3;
        idle(10);
        fetch_chk(32'h8000, 0, 0, 4, "R4 loop first miss");
        for (int k = 1; k < 8; k++) fetch_chk(32'h8000 + 32'(4 * k), 0, 0, 0, "R4 loop first pass");
        for (int p = 0; p < 2; p++) begin
            for (int k = 0; k < 8; k++) begin
                access(32'h8000 + 32'(4 * k), 0, 0, w, v);
                sum += w;
            end
        end
        idle(10);
        chk(sum == 0, "R4 backward branch loop no stall", 32'(sum), 0);
    endtask

    task automatic t_await_r6();
        rdc = 6;
        idle(10);
        fetch_chk(32'h900C, 0, 0, 7, "R6 setup miss");
        fetch_chk(32'h9020, 0, 0, 6, "R6 waits on in-flight prefetch");
        idle(10);
    endtask

    task automatic t_cancel_r7();
        rdc = 6;
        idle(10);
        fetch_chk(32'hA00C, 0, 0, 7, "R7 setup miss");
        fetch_chk(32'hA400, 0, 0, 7, "R7 branch restarts bank");
        idle(10);
        fetch_chk(32'hA020, 0, 0, 7, "R7 cancelled line not stored");
        idle(10);
    endtask

    task automatic t_data_r9();
        rdc = 3;
        idle(10);
        fetch_chk(32'hB000, 0, 0, 4, "R9 instruction setup");
        fetch_chk(32'hC01C, 1, 0, 4, "R9 data miss");
        fetch_chk(32'hC010, 1, 0, 0, "R9 data hit");
        fetch_chk(32'hC012, 1, 1, 0, "R9 data halfword hit");
        idle(6);
        fetch_chk(32'hC03C, 1, 0, 4, "R9 no data prefetch");
        fetch_chk(32'hB004, 0, 0, 0, "R9 instruction buffers kept");
        fetch_chk(32'hC010, 0, 0, 4, "R9 data line not an instruction hit");
        idle(10);
    endtask

    initial begin
        req = 1'b0; isd = 1'b0; half = 1'b0; addr = '0; rdc = 3;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_r10();
        t_miss_pair_r3();
        t_timing_r8();
        t_select_r2();
        t_pref_r5();
        t_stream_r5();
        t_loop_r4();
        t_await_r6();
        t_cancel_r7();
        t_data_r9();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule